// File: doc/BRIEF.md
# Performance-State Descriptor Table Validator

This block receives a performance-state descriptor table as a stream of bytes over a valid/ready handshake. The table is a fixed 24-byte header followed by a list of frequency-id / voltage-id pairs. The block checks the header's signature, version and flag bytes. It unpacks the timing fields and the packed control byte, and loads the pairs into a register file. It sorts the pairs by frequency id and then walks the sorted list against the ordering, parity, range and voltage-headroom rules.

When the block finishes a table, it raises a one-cycle completion strobe together with a pass flag and a reason code. It also presents the decoded parameters: voltage settle time, PLL lock time, ramp offset, isochronous relief exponent, voltage step size, state count and battery-limited state count. A power-management sequencer reads these parameters before it uses the table. Tables follow one another back to back on the same stream. The byte after the last one consumed always starts a new header.

Top module: `pst_table_check`

## Requirements
- R1: The header is 24 bytes, multi-byte fields little-endian. Bytes 0-9 must equal the 10-character signature parameter, or the code is 1. The other bytes are: 10 version, 11 reserved flags, 12-13 settle time, 14 packed control byte, 15 table count, 16-19 processor id, 20 PLL lock time, 21 top fid, 22 top vid, 23 state count.
- R2: A version other than 0x14 gives code 2, a nonzero reserved flags byte gives code 3, and a table count other than 1 gives code 4. When several header rules fail, the one at the earliest byte is reported.
- R3: In the control byte, bits 1:0 are the ramp offset and bits 3:2 are the relief exponent. Bits 5:4 are the step exponent, and the step output is 1 shifted left by it. The settle time and PLL lock time are presented as received.
- R4: A state count below 2 gives code 5, and a count above MAX_ENT (16) gives code 6. On any header error no pair bytes are consumed.
- R5: Control bits 7:6 give the battery count. A value of 0 means all states. A value above the state count is clamped to the state count. An effective battery count of 1 gives code 7.
- R6: Pairs, fid byte first and then vid byte, may arrive in any order. Up to MAX_ENT pairs are sorted ascending by fid before checking, so a legal table passes in any arrival order.
- R7: The lowest-fid entry must have an even fid no greater than 0x2a and a vid no greater than 0x1e, or the code is 8.
- R8: Each later entry must have an even fid, strictly above the previous one, in 0x08..0x2a, with vid no greater than 0x1e, or the code is 9.
- R9: After R7/R8 pass for all entries, each entry in ascending order is checked. A vid below the ramp offset gives code 10. Otherwise a vid below top-vid plus ramp offset gives code 11.
- R10: Ready is low from the last header byte until a header error is reported, and from the last pair byte until the result. done_o is a one-cycle pulse. pass_o is high exactly when the code is 0, and the result holds until the next completion.
- R11: After reset, ready is high, done_o and pass_o are low and the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block accepts a byte |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | Table accepted |
| err_o | output | 4 | Reason code, 0 when accepted |
| num_states_o | output | 8 | State count from the header |
| bat_states_o | output | 8 | Effective battery-limited state count |
| volt_settle_o | output | 16 | Voltage settle time |
| pll_lock_o | output | 8 | PLL lock time |
| ramp_off_o | output | 2 | Ramp voltage offset |
| iso_relief_o | output | 2 | Isochronous relief exponent |
| vid_step_o | output | 4 | Maximum voltage step size |

## Verification
The bench feeds the same legal table in sorted, shuffled and fully reversed order, including the full 16-entry case. A sort that stops after one pass, or that compares the wrong neighbours, would then report an ordering error on a good table. Duplicate fids, an odd first fid, a later fid under 8 or over 0x2a, and vids that break either headroom bound each check that the right code comes out. Getting the rule order wrong, or using a non-strict compare, would return a different code. Header cases cover two simultaneous header faults, an undersized or oversized state count, and the battery clamp, zero and one values. After each header error the stream continues, so a block that consumed pair bytes or lost byte alignment would corrupt the tables that follow.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int SIG_LEN    = 10;
  localparam int HDR_BYTES  = SIG_LEN + 14;
  localparam int OFF_VER    = SIG_LEN;
  localparam int OFF_F1     = SIG_LEN + 1;
  localparam int OFF_VST_LO = SIG_LEN + 2;
  localparam int OFF_VST_HI = SIG_LEN + 3;
  localparam int OFF_CTRL   = SIG_LEN + 4;
  localparam int OFF_NTBL   = SIG_LEN + 5;
  localparam int OFF_PLL    = SIG_LEN + 10;
  localparam int OFF_MAXVID = SIG_LEN + 12;
  localparam int OFF_NST    = SIG_LEN + 13;

  localparam logic [7:0] TBL_VERSION = 8'h14;
  localparam logic [7:0] FID_CEIL    = 8'h2a;
  localparam logic [7:0] FID_HI_MIN  = 8'h08;
  localparam logic [7:0] VID_CEIL    = 8'h1e;

  typedef enum logic [3:0] {
    ERR_NONE    = 4'd0,
    ERR_SIG     = 4'd1,
    ERR_VER     = 4'd2,
    ERR_FLAGS   = 4'd3,
    ERR_NTBL    = 4'd4,
    ERR_FEW     = 4'd5,
    ERR_MANY    = 4'd6,
    ERR_BAT     = 4'd7,
    ERR_FIRST   = 4'd8,
    ERR_ORDER   = 4'd9,
    ERR_VID_RVO = 4'd10,
    ERR_VID_MAX = 4'd11
  } err_e;

  typedef struct packed {
    logic [7:0] fid;
    logic [7:0] vid;
  } pair_t;
endpackage

// File: rtl/pst_hdr_parse.sv
module pst_hdr_parse
  import pst_pkg::*;
#(
  parameter logic [8*SIG_LEN-1:0] SIG = "PSTATETBL!",
  parameter int MAX_ENT = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        take_i,
  input  logic [7:0]  byte_i,
  output logic        last_o,
  output err_e        err_o,
  output logic [7:0]  nst_o,
  output logic [7:0]  bat_o,
  output logic [15:0] vst_o,
  output logic [7:0]  pll_o,
  output logic [7:0]  maxvid_o,
  output logic [1:0]  rvo_o,
  output logic [1:0]  irt_o,
  output logic [1:0]  mvs_o
);
  localparam int CW = $clog2(HDR_BYTES);

  logic [CW-1:0] idx_q;
  err_e          err_q, err_prev, err_hit, err_next;
  logic [7:0]    ctrl_q, nst_q, bat_q, pll_q, maxvid_q;
  logic [15:0]   vst_q;
  logic [7:0]    bat_field, bat_eff;
  int            sig_sel;

  assign last_o    = (idx_q == CW'(HDR_BYTES - 1));
  assign bat_field = {6'd0, ctrl_q[7:6]};
  assign bat_eff   = (bat_field == 8'd0 || bat_field > byte_i) ? byte_i : bat_field;
  assign sig_sel   = (int'(idx_q) < SIG_LEN) ? int'(idx_q) : 0;

  always_comb begin
    err_prev = (idx_q == '0) ? ERR_NONE : err_q;
    err_hit  = ERR_NONE;
    case (int'(idx_q))
      OFF_VER:  if (byte_i != TBL_VERSION) err_hit = ERR_VER;
      OFF_F1:   if (byte_i != 8'd0)        err_hit = ERR_FLAGS;
      OFF_NTBL: if (byte_i != 8'd1)        err_hit = ERR_NTBL;
      OFF_NST: begin
        if (byte_i < 8'd2)                 err_hit = ERR_FEW;
        else if (byte_i > 8'(MAX_ENT))     err_hit = ERR_MANY;
        else if (bat_eff < 8'd2)           err_hit = ERR_BAT;
      end
      default: begin
        if (int'(idx_q) < SIG_LEN && byte_i != SIG[8*(SIG_LEN-1-sig_sel) +: 8])
          err_hit = ERR_SIG;
      end
    endcase
    err_next = (err_prev != ERR_NONE) ? err_prev : err_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      err_q    <= ERR_NONE;
      ctrl_q   <= '0;
      nst_q    <= '0;
      bat_q    <= '0;
      pll_q    <= '0;
      maxvid_q <= '0;
      vst_q    <= '0;
    end else if (take_i) begin
      idx_q <= last_o ? '0 : idx_q + CW'(1);
      err_q <= err_next;
      case (int'(idx_q))
        OFF_VST_LO: vst_q[7:0]  <= byte_i;
        OFF_VST_HI: vst_q[15:8] <= byte_i;
        OFF_CTRL:   ctrl_q      <= byte_i;
        OFF_PLL:    pll_q       <= byte_i;
        OFF_MAXVID: maxvid_q    <= byte_i;
        OFF_NST: begin
          nst_q <= byte_i;
          bat_q <= bat_eff;
        end
        default: ;
      endcase
    end
  end

  assign err_o    = err_q;
  assign nst_o    = nst_q;
  assign bat_o    = bat_q;
  assign vst_o    = vst_q;
  assign pll_o    = pll_q;
  assign maxvid_o = maxvid_q;
  assign rvo_o    = ctrl_q[1:0];
  assign irt_o    = ctrl_q[3:2];
  assign mvs_o    = ctrl_q[5:4];
endmodule

// File: rtl/pst_sort.sv
module pst_sort
  import pst_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  pair_t             wr_pair_i,
  input  logic              start_i,
  input  logic [IW:0]       cnt_i,
  output logic              done_o,
  output pair_t [N-1:0]     tab_o
);
  pair_t [N-1:0] tab_q;
  logic          busy_q, swp_q, done_q;
  logic [IW-1:0] pos_q, pos_nx;
  pair_t         lo_e, hi_e;
  logic          do_swap, pass_end;

  assign pos_nx   = pos_q + IW'(1);
  assign lo_e     = tab_q[pos_q];
  assign hi_e     = tab_q[pos_nx];
  assign do_swap  = lo_e.fid > hi_e.fid;
  assign pass_end = ({1'b0, pos_q} == cnt_i - (IW+1)'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tab_q  <= '0;
      busy_q <= 1'b0;
      swp_q  <= 1'b0;
      done_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_i) tab_q[wr_idx_i] <= wr_pair_i;
      if (start_i) begin
        busy_q <= 1'b1;
        pos_q  <= '0;
        swp_q  <= 1'b0;
      end else if (busy_q) begin
        if (do_swap) begin
          tab_q[pos_q] <= hi_e;
          tab_q[pos_nx] <= lo_e;
        end
        if (pass_end) begin
          pos_q <= '0;
          swp_q <= 1'b0;
          // a pass without any exchange ends the sort
          if (!(swp_q || do_swap)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          pos_q <= pos_nx;
          swp_q <= swp_q | do_swap;
        end
      end
    end
  end

  assign done_o = done_q;
  assign tab_o  = tab_q;
endmodule

// File: rtl/pst_scan.sv
module pst_scan
  import pst_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW:0]   cnt_i,
  input  logic [1:0]    rvo_i,
  input  logic [7:0]    maxvid_i,
  input  pair_t [N-1:0] tab_i,
  output logic          done_o,
  output err_e          err_o
);
  logic          busy_q, head_q, done_q;
  logic [IW-1:0] j_q;
  err_e          err_q, hit;
  pair_t         cur, prv;
  logic          at_end;
  logic [8:0]    vid_w, need_w;

  assign cur    = tab_i[j_q];
  assign prv    = tab_i[j_q - IW'(1)];
  assign at_end = ({1'b0, j_q} == cnt_i - (IW+1)'(1));
  assign vid_w  = {1'b0, cur.vid};
  assign need_w = {1'b0, maxvid_i} + {7'd0, rvo_i};

  always_comb begin
    hit = ERR_NONE;
    if (!head_q) begin
      if (j_q == '0) begin
        if (cur.fid > FID_CEIL || cur.fid[0] || cur.vid > VID_CEIL) hit = ERR_FIRST;
      end else if (prv.fid >= cur.fid || cur.fid[0] || cur.fid < FID_HI_MIN ||
                   cur.fid > FID_CEIL || cur.vid > VID_CEIL) begin
        hit = ERR_ORDER;
      end
    end else begin
      if (vid_w < {7'd0, rvo_i})  hit = ERR_VID_RVO;
      else if (vid_w < need_w)    hit = ERR_VID_MAX;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      head_q <= 1'b0;
      done_q <= 1'b0;
      j_q    <= '0;
      err_q  <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        head_q <= 1'b0;
        j_q    <= '0;
        err_q  <= ERR_NONE;
      end else if (busy_q) begin
        if (hit != ERR_NONE) begin
          err_q  <= hit;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (at_end) begin
          j_q <= '0;
          if (head_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            head_q <= 1'b1;
          end
        end else begin
          j_q <= j_q + IW'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pst_table_check.sv
module pst_table_check
  import pst_pkg::*;
#(
  parameter logic [8*SIG_LEN-1:0] SIG = "PSTATETBL!",
  parameter int MAX_ENT = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  output logic        in_ready_o,
  output logic        done_o,
  output logic        pass_o,
  output logic [3:0]  err_o,
  output logic [7:0]  num_states_o,
  output logic [7:0]  bat_states_o,
  output logic [15:0] volt_settle_o,
  output logic [7:0]  pll_lock_o,
  output logic [1:0]  ramp_off_o,
  output logic [1:0]  iso_relief_o,
  output logic [3:0]  vid_step_o
);
  localparam int IW = $clog2(MAX_ENT);

  typedef enum logic [2:0] {S_HDR, S_EVAL, S_ENT, S_SORT, S_SCAN} st_e;

  st_e           st_q;
  logic          take, hdr_take, hdr_last, ent_wr, ent_last;
  logic          half_q, done_q, pass_q;
  logic [IW-1:0] ent_idx_q;
  logic [7:0]    fid_q, maxvid;
  err_e          err_q, hdr_err, scan_err;
  logic [1:0]    mvs;
  logic          sort_done, scan_done;
  pair_t [MAX_ENT-1:0] tab;
  logic [IW:0]   cnt;

  assign in_ready_o = (st_q == S_HDR) || (st_q == S_ENT);
  assign take       = in_valid_i && in_ready_o;
  assign hdr_take   = take && (st_q == S_HDR);
  assign ent_wr     = take && (st_q == S_ENT) && half_q;
  assign cnt        = num_states_o[IW:0];
  assign ent_last   = ({1'b0, ent_idx_q} == cnt - (IW+1)'(1));

  pst_hdr_parse #(.SIG(SIG), .MAX_ENT(MAX_ENT)) u_hdr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (hdr_take),
    .byte_i  (in_data_i),
    .last_o  (hdr_last),
    .err_o   (hdr_err),
    .nst_o   (num_states_o),
    .bat_o   (bat_states_o),
    .vst_o   (volt_settle_o),
    .pll_o   (pll_lock_o),
    .maxvid_o(maxvid),
    .rvo_o   (ramp_off_o),
    .irt_o   (iso_relief_o),
    .mvs_o   (mvs)
  );

  pst_sort #(.N(MAX_ENT)) u_sort (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ent_wr),
    .wr_idx_i (ent_idx_q),
    .wr_pair_i({fid_q, in_data_i}),
    .start_i  (ent_wr && ent_last),
    .cnt_i    (cnt),
    .done_o   (sort_done),
    .tab_o    (tab)
  );

  pst_scan #(.N(MAX_ENT)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sort_done),
    .cnt_i   (cnt),
    .rvo_i   (ramp_off_o),
    .maxvid_i(maxvid),
    .tab_i   (tab),
    .done_o  (scan_done),
    .err_o   (scan_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_HDR;
      half_q    <= 1'b0;
      ent_idx_q <= '0;
      fid_q     <= '0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_HDR: if (hdr_take && hdr_last) st_q <= S_EVAL;
        S_EVAL: begin
          if (hdr_err != ERR_NONE) begin
            done_q <= 1'b1;
            pass_q <= 1'b0;
            err_q  <= hdr_err;
            st_q   <= S_HDR;
          end else begin
            half_q    <= 1'b0;
            ent_idx_q <= '0;
            st_q      <= S_ENT;
          end
        end
        S_ENT: begin
          if (take) begin
            if (!half_q) begin
              fid_q  <= in_data_i;
              half_q <= 1'b1;
            end else begin
              half_q    <= 1'b0;
              ent_idx_q <= ent_idx_q + IW'(1);
              if (ent_last) st_q <= S_SORT;
            end
          end
        end
        S_SORT: if (sort_done) st_q <= S_SCAN;
        S_SCAN: begin
          if (scan_done) begin
            done_q <= 1'b1;
            pass_q <= (scan_err == ERR_NONE);
            err_q  <= scan_err;
            st_q   <= S_HDR;
          end
        end
        default: st_q <= S_HDR;
      endcase
    end
  end

  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign err_o      = err_q;
  assign vid_step_o = 4'd1 << mvs;
endmodule

// File: rtl/pst_table_check_sva.sv
module pst_table_check_sva #(
  parameter int MAX_ENT = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_o,
  input logic       done_o,
  input logic       pass_o,
  input logic [3:0] err_o,
  input logic [7:0] num_states_o,
  input logic [7:0] bat_states_o
);
  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> in_ready_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_PASS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o == (err_o == 4'd0))); // R10
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != $past(err_o)) |-> done_o); // R10
  AST_BAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (bat_states_o >= 8'd2 && bat_states_o <= num_states_o)); // R5
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (num_states_o >= 8'd2 && num_states_o <= 8'(MAX_ENT))); // R4
endmodule

bind pst_table_check pst_table_check_sva #(.MAX_ENT(MAX_ENT)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .err_o       (err_o),
  .num_states_o(num_states_o),
  .bat_states_o(bat_states_o)
);

// File: tb/tb_pst_table_check.sv
module tb_pst_table_check;
  localparam logic [79:0] SIG = "PSTATETBL!";

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = 8'd0;
  logic        in_ready_o, done_o, pass_o;
  logic [3:0]  err_o, vid_step_o;
  logic [7:0]  num_states_o, bat_states_o, pll_lock_o;
  logic [15:0] volt_settle_o;
  logic [1:0]  ramp_off_o, iso_relief_o;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  pst_table_check dut (.*);

  typedef struct packed {
    logic        sig_bad;
    logic [7:0]  ver, f1, ctrl, ntbl, maxvid, nst;
    logic [63:0] ents;
    logic [3:0]  exp_err;
    logic [7:0]  exp_bat;
  } vec_t;

  // pair k at ents[16k+:16] as {fid, vid}
  localparam vec_t VECS [20] = '{
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd3,  64'h0000_0c0e_0a10_0212, 4'd0,  8'd3}, // R6 sorted
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd3,  64'h0000_0a10_0212_0c0e, 4'd0,  8'd3}, // R6 shuffled
    '{1'b1, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd3,  64'h0000_0c0e_0a10_0212, 4'd1,  8'd0}, // R1
    '{1'b0, 8'h13, 8'h00, 8'h00, 8'h01, 8'h00, 8'd3,  64'h0000_0c0e_0a10_0212, 4'd2,  8'd0}, // R2
    '{1'b0, 8'h14, 8'h01, 8'h00, 8'h01, 8'h00, 8'd3,  64'h0000_0c0e_0a10_0212, 4'd3,  8'd0}, // R2
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h02, 8'h00, 8'd3,  64'h0000_0c0e_0a10_0212, 4'd4,  8'd0}, // R2
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd1,  64'h0000_0c0e_0a10_0212, 4'd5,  8'd0}, // R4
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd17, 64'h0000_0c0e_0a10_0212, 4'd6,  8'd0}, // R4
    '{1'b0, 8'h14, 8'h00, 8'h40, 8'h01, 8'h00, 8'd3,  64'h0000_0c0e_0a10_0212, 4'd7,  8'd0}, // R5
    '{1'b0, 8'h14, 8'h00, 8'hc0, 8'h01, 8'h00, 8'd2,  64'h0000_0000_0a10_0212, 4'd0,  8'd2}, // R5 clamp
    '{1'b0, 8'h14, 8'h00, 8'h80, 8'h01, 8'h00, 8'd3,  64'h0000_0c0e_0a10_0212, 4'd0,  8'd2}, // R5 limit
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd2,  64'h0000_0000_0a10_0312, 4'd8,  8'd0}, // R7 odd
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd2,  64'h0000_0000_0a10_021f, 4'd8,  8'd0}, // R7 vid
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd2,  64'h0000_0000_0a0f_0a10, 4'd9,  8'd0}, // R8 dup
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd2,  64'h0000_0000_0410_0212, 4'd9,  8'd0}, // R8 low
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd2,  64'h0000_0000_2c10_0212, 4'd9,  8'd0}, // R8 high
    '{1'b0, 8'h14, 8'h00, 8'h03, 8'h01, 8'h00, 8'd2,  64'h0000_0000_0a02_0212, 4'd10, 8'd0}, // R9 rvo
    '{1'b0, 8'h14, 8'h00, 8'h01, 8'h01, 8'h10, 8'd2,  64'h0000_0000_0a10_0212, 4'd11, 8'd0}, // R9 maxvid
    '{1'b0, 8'h13, 8'h01, 8'h00, 8'h01, 8'h00, 8'd3,  64'h0000_0c0e_0a10_0212, 4'd2,  8'd0}, // R2 priority
    '{1'b0, 8'h14, 8'h00, 8'h00, 8'h01, 8'h00, 8'd3,  64'h0000_0212_0a10_0c0e, 4'd0,  8'd3}  // R6 reversed
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    int c = 0;
    in_valid_i = 1'b1;
    in_data_i  = b;
    while (!in_ready_o && c < 4000) begin
      @(negedge clk_i);
      c++;
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic send_tbl(input logic sig_bad, input logic [7:0] ver, input logic [7:0] f1,
                          input logic [15:0] vst, input logic [7:0] ctrl, input logic [7:0] ntbl,
                          input logic [7:0] pll, input logic [7:0] maxvid, input logic [7:0] nst,
                          input int n_ent, input logic [255:0] ents);
    for (int k = 0; k < 10; k++)
      send_byte(SIG[8*(9-k) +: 8] ^ ((sig_bad && k == 3) ? 8'h01 : 8'h00));
    send_byte(ver);
    send_byte(f1);
    send_byte(vst[7:0]);
    send_byte(vst[15:8]);
    send_byte(ctrl);
    send_byte(ntbl);
    send_byte(8'ha5);
    send_byte(8'h0f);
    send_byte(8'h5a);
    send_byte(8'hf0);
    send_byte(pll);
    send_byte(8'h2a);
    send_byte(maxvid);
    send_byte(nst);
    for (int k = 0; k < n_ent; k++) begin
      send_byte(ents[16*k+8 +: 8]);
      send_byte(ents[16*k +: 8]);
    end
  endtask

  task automatic wait_done();
    int c = 0;
    while (!done_o && c < 4000) begin
      @(negedge clk_i);
      c++;
    end
    if (!done_o) begin
      n_vec++;
      n_bad++;
      $display("FAIL R10: completion strobe missing, got 0 expected 1");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] big;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 ready", 32'(in_ready_o), 32'd1);
    chk("R11 done", 32'(done_o), 32'd0);
    chk("R11 err", 32'(err_o), 32'd0);
    chk("R11 pass", 32'(pass_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VECS[i]) begin
      int n_ent;
      n_ent = (VECS[i].exp_err == 4'd0 || VECS[i].exp_err >= 4'd8) ? int'(VECS[i].nst) : 0;
      send_tbl(VECS[i].sig_bad, VECS[i].ver, VECS[i].f1, 16'h0000, VECS[i].ctrl, VECS[i].ntbl,
               8'h00, VECS[i].maxvid, VECS[i].nst, n_ent, {192'd0, VECS[i].ents});
      wait_done();
      chk($sformatf("R1..vector %0d code", i), 32'(err_o), 32'(VECS[i].exp_err));
      chk($sformatf("R10 vector %0d pass", i), 32'(pass_o), 32'(VECS[i].exp_err == 4'd0));
      if (VECS[i].exp_err == 4'd0)
        chk($sformatf("R5 vector %0d battery", i), 32'(bat_states_o), 32'(VECS[i].exp_bat));
      @(negedge clk_i);
      chk("R10 strobe width", 32'(done_o), 32'd0);
    end

    // R3 field decode: ctrl 0x27 -> ramp 3, relief 1, step 4
    send_tbl(1'b0, 8'h14, 8'h00, 16'h1234, 8'h27, 8'h01, 8'h55, 8'h00, 8'd2, 2,
             {224'd0, 32'h0a10_0212});
    wait_done();
    chk("R3 pass", 32'(pass_o), 32'd1);
    chk("R3 ramp", 32'(ramp_off_o), 32'd3);
    chk("R3 relief", 32'(iso_relief_o), 32'd1);
    chk("R3 step", 32'(vid_step_o), 32'd4);
    chk("R3 settle", 32'(volt_settle_o), 32'h1234);
    chk("R3 pll", 32'(pll_lock_o), 32'h55);
    chk("R5 all states", 32'(bat_states_o), 32'd2);

    // R3 ctrl 0xd8 -> ramp 0, relief 2, step 2, battery 3
    send_tbl(1'b0, 8'h14, 8'h00, 16'hbeef, 8'hd8, 8'h01, 8'h07, 8'h00, 8'd3, 3,
             {208'd0, 48'h0c0e_0212_0a10});
    wait_done();
    chk("R3 pass b", 32'(pass_o), 32'd1);
    chk("R3 ramp b", 32'(ramp_off_o), 32'd0);
    chk("R3 relief b", 32'(iso_relief_o), 32'd2);
    chk("R3 step b", 32'(vid_step_o), 32'd2);
    chk("R5 battery b", 32'(bat_states_o), 32'd3);

    // R6 full table in descending order
    big = '0;
    for (int k = 0; k < 16; k++) big[16*k +: 16] = {8'(8'h2a - 2*k), 8'h10};
    send_tbl(1'b0, 8'h14, 8'h00, 16'h0001, 8'h00, 8'h01, 8'h01, 8'h00, 8'd16, 16, big);
    chk("R10 ready low while sorting", 32'(in_ready_o), 32'd0);
    wait_done();
    chk("R6 full reversed", 32'(err_o), 32'd0);
    chk("R4 max count", 32'(num_states_o), 32'd16);
    chk("R5 full battery", 32'(bat_states_o), 32'd16);

    // R8 error at the top of a full table: last two fids equal after sort
    big[16*15 +: 16] = {8'h2a, 8'h10};
    send_tbl(1'b0, 8'h14, 8'h00, 16'h0001, 8'h00, 8'h01, 8'h01, 8'h00, 8'd16, 16, big);
    wait_done();
    chk("R8 duplicate in full table", 32'(err_o), 32'd9);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule